// File: doc/BRIEF.md
# Byte-Lane Data Memory with Read-Only Constant Words

This block is the load/store memory of a small 32-bit integer core. A 1024-bit writable array, 32 words of 32 bits, sits at the bottom of the byte address space. Three read-only constant words sit at a fixed higher base address. The core presents a byte address together with the three-bit width/sign code taken from its load or store instruction. A store writes one, two or four byte lanes on the rising clock edge. A load returns the selected byte, halfword or word combinationally, sign- or zero-extended to 32 bits.

A synchronous, active-high reset wipes the whole array. The constant words never change. Any address that falls in neither region reads as zero, and a store to such an address is dropped. It is never folded onto the array.

Top module: `byte_data_mem`

## Requirements
- R1: A clock edge with `rst` high clears all 32 writable words to zero. A store presented in that same cycle is discarded.
- R2: While `rd_en` is low, `rd_data` is zero whatever the address and code.
- R3: Code 3'b010 loads the full word. The word is selected by `addr[6:2]` in the array, and `addr[1:0]` is ignored.
- R4: Code 3'b000 returns the byte in lane `addr[1:0]`, sign-extended. Code 3'b100 returns the same byte, zero-extended. Lane 0 is bits 7:0 (little-endian).
- R5: Code 3'b001 returns the halfword chosen by `addr[1]` (0 gives bits 15:0, 1 gives bits 31:16), sign-extended. Code 3'b101 returns it zero-extended. `addr[0]` is ignored.
- R6: With `wr_en` high, code 3'b000 stores `wr_data[7:0]` into lane `addr[1:0]`. Code 3'b001 stores `wr_data[15:0]` into the lane pair picked by `addr[1]`. Code 3'b010 stores all four lanes. Lanes that are not written keep their contents.
- R7: A store takes effect at the rising edge. A load to the same word in the same cycle returns the contents from before that edge.
- R8: Constant word k (k = 0, 1, 2) is at byte address 0x00100000 + 4k and holds 0xC0A57000 + k. Every load code works on it.
- R9: Stores aimed at the constant words are ignored, and the constants keep their values.
- R10: The writable array occupies byte addresses 0x00 to 0x7F. Loads from addresses outside the array and outside the constant words return zero. Stores to such addresses change nothing, including no aliasing onto the array.
- R11: Load codes 3'b011, 3'b110 and 3'b111 return zero. Store codes other than 3'b000, 3'b001 and 3'b010 write nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high clear of the array |
| wr_en | input | 1 | Store request |
| rd_en | input | 1 | Load request; output is zero when low |
| addr | input | 32 | Byte address |
| wr_data | input | 32 | Store data, right-aligned |
| funct3 | input | 3 | Access width and sign code |
| rd_data | output | 32 | Extended load result |

## Verification
Two actions can fall in the same cycle, and the bench provokes both pairs. In the first, a store and a load both target one array word. The bench expects the load to show the old word and the following load to show the new one. In the second, reset coincides with a store. The bench judges this pair by reading the targeted word and a neighbouring word afterwards and expecting zero in both.

// File: rtl/dmem_pkg.sv
package dmem_pkg;

    localparam int unsigned XLEN  = 32;
    localparam int unsigned LANES = XLEN / 8;

    typedef enum logic [2:0] {
        ACC_B  = 3'b000,
        ACC_H  = 3'b001,
        ACC_W  = 3'b010,
        ACC_BU = 3'b100,
        ACC_HU = 3'b101
    } acc_kind_e;

    typedef enum logic [1:0] {
        RGN_NONE  = 2'd0,
        RGN_RAM   = 2'd1,
        RGN_CONST = 2'd2
    } region_e;

    typedef struct packed {
        region_e            region;
        acc_kind_e          kind;
        logic [1:0]         boff;
        logic [LANES-1:0]   lanes;
        logic               ld_ok;
        logic               st_ok;
    } acc_t;

    // value of read-only constant k
    function automatic logic [XLEN-1:0] const_word(input int unsigned k);
        return 32'hC0A5_7000 + XLEN'(k);
    endfunction

    function automatic logic ld_legal(input logic [2:0] f3);
        return (f3 == ACC_B) || (f3 == ACC_H) || (f3 == ACC_W) ||
               (f3 == ACC_BU) || (f3 == ACC_HU);
    endfunction

    function automatic logic st_legal(input logic [2:0] f3);
        return (f3 == ACC_B) || (f3 == ACC_H) || (f3 == ACC_W);
    endfunction

    // byte lanes touched by a store
    function automatic logic [LANES-1:0] lane_mask(input logic [2:0] f3,
                                                   input logic [1:0] boff);
        logic [LANES-1:0] m;
        case (f3)
            ACC_B:   m = LANES'(1) << boff;
            ACC_H:   m = boff[1] ? 4'b1100 : 4'b0011;
            ACC_W:   m = 4'b1111;
            default: m = '0;
        endcase
        return m;
    endfunction

    // place store data on every lane it may target
    function automatic logic [XLEN-1:0] spread(input logic [2:0] f3,
                                               input logic [XLEN-1:0] d);
        logic [XLEN-1:0] r;
        case (f3)
            ACC_B:   r = {4{d[7:0]}};
            ACC_H:   r = {2{d[15:0]}};
            default: r = d;
        endcase
        return r;
    endfunction

    // select and extend a load result
    function automatic logic [XLEN-1:0] extend(input acc_kind_e k,
                                               input logic [1:0] boff,
                                               input logic [XLEN-1:0] w);
        logic [7:0]  b;
        logic [15:0] h;
        logic [XLEN-1:0] r;
        b = w[8*boff +: 8];
        h = boff[1] ? w[31:16] : w[15:0];
        case (k)
            ACC_B:   r = {{24{b[7]}}, b};
            ACC_BU:  r = {24'd0, b};
            ACC_H:   r = {{16{h[15]}}, h};
            ACC_HU:  r = {16'd0, h};
            ACC_W:   r = w;
            default: r = '0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/dmem_decode.sv
module dmem_decode
    import dmem_pkg::*;
#(
    parameter int unsigned       WORDS      = 32,
    parameter int unsigned       NUM_CONST  = 3,
    parameter logic [XLEN-1:0]   CONST_BASE = 32'h0010_0000,
    localparam int unsigned      AW         = $clog2(WORDS),
    localparam int unsigned      CW         = (NUM_CONST > 1) ? $clog2(NUM_CONST) : 1
) (
    input  logic [XLEN-1:0] addr,
    input  logic [2:0]      funct3,
    output acc_t            acc,
    output logic [AW-1:0]   ram_idx,
    output logic [CW-1:0]   const_idx
);

    logic            in_ram;
    logic            in_const;
    logic [XLEN-3:0] woff;

    assign in_ram   = (addr[XLEN-1:AW+2] == '0);
    assign woff     = addr[XLEN-1:2] - CONST_BASE[XLEN-1:2];
    assign in_const = (woff < (XLEN-2)'(NUM_CONST));

    assign ram_idx   = addr[AW+1:2];
    assign const_idx = woff[CW-1:0];

    always_comb begin
        acc.region = in_ram   ? RGN_RAM   :
                     in_const ? RGN_CONST : RGN_NONE;
        acc.kind   = acc_kind_e'(funct3);
        acc.boff   = addr[1:0];
        acc.lanes  = lane_mask(funct3, addr[1:0]);
        acc.ld_ok  = ld_legal(funct3);
        acc.st_ok  = st_legal(funct3);
    end

endmodule

// File: rtl/dmem_array.sv
module dmem_array
    import dmem_pkg::*;
#(
    parameter int unsigned  WORDS = 32,
    localparam int unsigned AW    = $clog2(WORDS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [AW-1:0]    idx,
    input  logic [LANES-1:0] lanes,
    input  logic [XLEN-1:0]  wdata,
    output logic [XLEN-1:0]  rword
);

    for (genvar b = 0; b < LANES; b++) begin : g_lane
        logic [7:0] lane_mem [WORDS];

        always_ff @(posedge clk) begin
            if (rst) begin
                for (int w = 0; w < WORDS; w++) lane_mem[w] <= '0;
            end else if (we && lanes[b]) begin
                lane_mem[idx] <= wdata[8*b +: 8];
            end
        end

        assign rword[8*b +: 8] = lane_mem[idx];
    end

endmodule

// File: rtl/dmem_const_rom.sv
module dmem_const_rom
    import dmem_pkg::*;
#(
    parameter int unsigned  NUM_CONST = 3,
    localparam int unsigned CW        = (NUM_CONST > 1) ? $clog2(NUM_CONST) : 1
) (
    input  logic [CW-1:0]   sel,
    output logic [XLEN-1:0] word
);

    logic [XLEN-1:0] table_w [NUM_CONST];

    for (genvar k = 0; k < NUM_CONST; k++) begin : g_const
        assign table_w[k] = const_word(k);
    end

    always_comb begin
        word = '0;
        for (int k = 0; k < NUM_CONST; k++) begin
            if (sel == CW'(k)) word = table_w[k];
        end
    end

endmodule

// File: rtl/byte_data_mem.sv
module byte_data_mem
    import dmem_pkg::*;
#(
    parameter int unsigned      WORDS      = 32,
    parameter int unsigned      NUM_CONST  = 3,
    parameter logic [XLEN-1:0]  CONST_BASE = 32'h0010_0000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic        rd_en,
    input  logic [31:0] addr,
    input  logic [31:0] wr_data,
    input  logic [2:0]  funct3,
    output logic [31:0] rd_data
);

    localparam int unsigned AW = $clog2(WORDS);
    localparam int unsigned CW = (NUM_CONST > 1) ? $clog2(NUM_CONST) : 1;

    acc_t            acc;
    logic [AW-1:0]   ram_idx;
    logic [CW-1:0]   const_idx;
    logic [XLEN-1:0] ram_word;
    logic [XLEN-1:0] rom_word;
    logic [XLEN-1:0] src_word;
    logic            ram_we;

    dmem_decode #(
        .WORDS(WORDS), .NUM_CONST(NUM_CONST), .CONST_BASE(CONST_BASE)
    ) u_dec (
        .addr(addr), .funct3(funct3), .acc(acc),
        .ram_idx(ram_idx), .const_idx(const_idx)
    );

    assign ram_we = wr_en && acc.st_ok && (acc.region == RGN_RAM);

    dmem_array #(.WORDS(WORDS)) u_ram (
        .clk(clk), .rst(rst), .we(ram_we), .idx(ram_idx),
        .lanes(acc.lanes), .wdata(spread(funct3, wr_data)), .rword(ram_word)
    );

    dmem_const_rom #(.NUM_CONST(NUM_CONST)) u_rom (
        .sel(const_idx), .word(rom_word)
    );

    always_comb begin
        case (acc.region)
            RGN_RAM:   src_word = ram_word;
            RGN_CONST: src_word = rom_word;
            default:   src_word = '0;
        endcase
        rd_data = (rd_en && acc.ld_ok) ? extend(acc.kind, acc.boff, src_word) : '0;
    end

endmodule

// File: rtl/byte_data_mem_chk.sv
module byte_data_mem_chk #(
    parameter int unsigned WORDS      = 32,
    parameter int unsigned NUM_CONST  = 3,
    parameter logic [31:0] CONST_BASE = 32'h0010_0000
) (
    input logic        clk,
    input logic        rst,
    input logic        wr_en,
    input logic        rd_en,
    input logic [31:0] addr,
    input logic [31:0] wr_data,
    input logic [2:0]  funct3,
    input logic [31:0] rd_data
);

    localparam int unsigned AW = $clog2(WORDS);

    logic        in_ram;
    logic [29:0] coff;
    assign in_ram = (addr[31:AW+2] == '0);
    assign coff   = addr[31:2] - CONST_BASE[31:2];

    // R2
    rden_gate_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_en |-> rd_data == 32'd0);

    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && $past(rst) && in_ram && funct3 == 3'b010) |-> rd_data == 32'd0);

    // R4
    lbu_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && funct3 == 3'b100) |-> rd_data[31:8] == 24'd0);

    // R4
    lb_sign_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && funct3 == 3'b000) |-> rd_data[31:8] == {24{rd_data[7]}});

    // R8
    const_base_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && funct3 == 3'b010 && addr == CONST_BASE) |-> rd_data == 32'hC0A5_7000);

    // R10
    outside_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !in_ram && coff >= 30'(NUM_CONST)) |-> rd_data == 32'd0);

    // R7
    store_visible_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && funct3 == 3'b010 && in_ram && !$past(rst) &&
         $past(wr_en && funct3 == 3'b010 && in_ram) &&
         $past(addr[AW+1:2]) == addr[AW+1:2]) |-> rd_data == $past(wr_data));

endmodule

bind byte_data_mem byte_data_mem_chk #(
    .WORDS(WORDS), .NUM_CONST(NUM_CONST), .CONST_BASE(CONST_BASE)
) u_chk (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wr_data(wr_data), .funct3(funct3), .rd_data(rd_data)
);

// File: tb/byte_data_mem_tb.sv
`timescale 1ns/1ps
module byte_data_mem_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [31:0] addr = '0;
    logic [31:0] wr_data = '0;
    logic [2:0]  funct3 = '0;
    logic [31:0] rd_data;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [31:0] exp_q [$];
    string       tag_q [$];

    always #2 clk = ~clk;   // 250 MHz

    byte_data_mem u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wr_data(wr_data), .funct3(funct3), .rd_data(rd_data)
    );

    // driver: one access per cycle, expected output queued
    task automatic op(input logic r, input logic we, input logic re,
                      input logic [31:0] a, input logic [2:0] f3,
                      input logic [31:0] wd, input logic [31:0] ex,
                      input string tag);
        @(negedge clk);
        rst = r; wr_en = we; rd_en = re; addr = a; funct3 = f3; wr_data = wd;
        exp_q.push_back(ex);
        tag_q.push_back(tag);
    endtask

    task automatic ld(input logic [31:0] a, input logic [2:0] f3,
                      input logic [31:0] ex, input string tag);
        op(1'b0, 1'b0, 1'b1, a, f3, 32'd0, ex, tag);
    endtask

    task automatic st(input logic [31:0] a, input logic [2:0] f3,
                      input logic [31:0] wd, input string tag);
        op(1'b0, 1'b1, 1'b0, a, f3, wd, 32'd0, tag);
    endtask

    // monitor: compare between edges
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (exp_q.size() > 0) begin
                logic [31:0] ex;
                string       tg;
                ex = exp_q.pop_front();
                tg = tag_q.pop_front();
                checks++;
                if (rd_data !== ex) begin
                    errors++;
                    $display("FAIL %s: rd_data=%h expected=%h", tg, rd_data, ex);
                end
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        ld(32'h0000_0000, 3'b010, 32'h0, "R1 word0 after reset");
        ld(32'h0000_007C, 3'b010, 32'h0, "R1 word31 after reset");
        st(32'h0000_0010, 3'b010, 32'h1122_3344, "R2 store with rd_en low");
        ld(32'h0000_0010, 3'b010, 32'h1122_3344, "R3 lw");
        ld(32'h0000_0013, 3'b010, 32'h1122_3344, "R3 lw low bits ignored");
        ld(32'h0000_0013, 3'b000, 32'h0000_0011, "R4 lb lane3");
        ld(32'h0000_0010, 3'b000, 32'h0000_0044, "R4 lb lane0");
        ld(32'h0000_0012, 3'b001, 32'h0000_1122, "R5 lh upper");
        ld(32'h0000_0013, 3'b001, 32'h0000_1122, "R5 lh addr0 ignored");
        st(32'h0000_0011, 3'b000, 32'hFFFF_FF80, "R6 sb");
        ld(32'h0000_0010, 3'b010, 32'h1122_8044, "R6 sb lanes kept");
        ld(32'h0000_0011, 3'b000, 32'hFFFF_FF80, "R4 lb negative");
        ld(32'h0000_0011, 3'b100, 32'h0000_0080, "R4 lbu");
        st(32'h0000_0016, 3'b001, 32'h1234_BEEF, "R6 sh");
        ld(32'h0000_0016, 3'b001, 32'hFFFF_BEEF, "R5 lh negative");
        ld(32'h0000_0016, 3'b101, 32'h0000_BEEF, "R5 lhu");
        ld(32'h0000_0014, 3'b010, 32'hBEEF_0000, "R6 sh lower kept");
        op(1'b0, 1'b0, 1'b0, 32'h0000_0010, 3'b010, 32'h0, 32'h0, "R2 rd_en low");
        ld(32'h0010_0000, 3'b010, 32'hC0A5_7000, "R8 const0");
        ld(32'h0010_0004, 3'b010, 32'hC0A5_7001, "R8 const1");
        ld(32'h0010_0008, 3'b010, 32'hC0A5_7002, "R8 const2");
        ld(32'h0010_0001, 3'b000, 32'h0000_0070, "R8 lb const");
        ld(32'h0010_0003, 3'b000, 32'hFFFF_FFC0, "R8 lb const neg");
        ld(32'h0010_0006, 3'b101, 32'h0000_C0A5, "R8 lhu const");
        ld(32'h0010_0006, 3'b001, 32'hFFFF_C0A5, "R8 lh const");
        st(32'h0010_0004, 3'b010, 32'h0000_0000, "R9 store to const");
        ld(32'h0010_0004, 3'b010, 32'hC0A5_7001, "R9 const unchanged");
        ld(32'h0000_0080, 3'b010, 32'h0, "R10 above array");
        ld(32'h0010_000C, 3'b010, 32'h0, "R10 above consts");
        ld(32'h000F_FFFC, 3'b010, 32'h0, "R10 below consts");
        st(32'h0000_0090, 3'b010, 32'hDEAD_BEEF, "R10 store outside");
        ld(32'h0000_0010, 3'b010, 32'h1122_8044, "R10 no aliasing");
        ld(32'h0000_0010, 3'b011, 32'h0, "R11 load code 011");
        ld(32'h0000_0010, 3'b110, 32'h0, "R11 load code 110");
        st(32'h0000_0010, 3'b011, 32'h0, "R11 store code 011");
        ld(32'h0000_0010, 3'b010, 32'h1122_8044, "R11 store ignored");
        op(1'b0, 1'b1, 1'b1, 32'h0000_0010, 3'b010, 32'hCAFE_F00D,
           32'h1122_8044, "R7 same-cycle old data");
        ld(32'h0000_0010, 3'b010, 32'hCAFE_F00D, "R7 new data next cycle");
        op(1'b1, 1'b1, 1'b0, 32'h0000_0014, 3'b010, 32'h0000_0055,
           32'h0, "R1 reset with store");
        ld(32'h0000_0014, 3'b010, 32'h0, "R1 store in reset discarded");
        ld(32'h0000_0010, 3'b010, 32'h0, "R1 array cleared");
        @(negedge clk);
        rd_en = 1'b0; wr_en = 1'b0;
        repeat (3) @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule